// File: doc/BRIEF.md
# PHY Management Register Bank

This block holds the control and status words of a physical-layer transceiver. It sits behind the management serial slave. That slave converts each decoded frame into a one-cycle read or write request on a simple parallel port. The bank keeps six words, at addresses 0, 1, 2, 3, 16 and 17. Every other address is treated as absent. Reads of an absent address return zero with the hit flag low, and writes to one are dropped.

Each bit has its own access policy:

- **Read-only:** the bit ignores writes.
- **Command-protected:** the bit takes a write only after the unlock bit in the extended control word has been set.
- **Zero-write-only:** the bit stores what is written, but software should write only 0 to it.
- **Read/write:** the bit takes any value.

Two command bits clear themselves a fixed number of clocks after being set. Event bits fed by the PHY core latch high or latch low. A latched value is released by the read that returned it, so a condition that is still present shows again on the following read. Several control bits take their reset value from strap pins.

Top module: `phy_regbank`

## Requirements
- R1: Addresses 0, 1, 2, 3, 16 and 17 answer with rsp_hit=1. Any other address answers with rsp_hit=0 and rsp_rdata=0, and a write to it changes nothing.
- R2: A read accepted at a clock edge gives rsp_valid=1 for exactly the following cycle, with rsp_rdata and rsp_hit for that read. Write requests produce no rsp_valid.
- R3: Address 2 returns parameter ID_HI and address 3 returns parameter ID_LO. Writes to either address have no effect.
- R4: Address 1 has the following fixed bits: bits 15:11 are parameter ABILITY, bit 3 is 1, bit 0 is 1, and bits 10:6 are 0. Addresses 1 and 17 ignore all writes.
- R5: Address 0 has three command-protected bits: bit 13 drives ctl_speed, bit 12 drives ctl_an_en and bit 8 drives ctl_duplex. A write to address 0 leaves these bits unchanged unless bit 15 of address 16 (the unlock bit) was already 1 before that write.
- R6: The plain read/write bits store any written value. They are address 0 bit 14 (ctl_loopback) and bit 10 (ctl_isolate), and address 16 bit 15 (unlock) and bit 0 (ctl_scramble_bypass).
- R7: The zero-write-only bits store the written value. They are address 0 bit 11 (ctl_power_down) and address 16 bits 14:12 (ctl_test_mode).
- R8: While rst_n is low, the bits take these values: bit 13 of address 0 takes strap_speed, bit 12 takes strap_an_en, bit 10 takes strap_isolate and bit 8 takes strap_duplex. Every other stored bit of addresses 0 and 16 becomes 0.
- R9: The latch-high bits are: remote fault at address 1 bit 4 and address 17 bit 1, jabber at address 1 bit 1, and receive error at address 17 bit 0. Each reads 1 once its input has been high on any clock edge since its word was last read. The read after that shows the live input.
- R10: The link bit at address 1 bit 2 and address 17 bit 15 reads 0 once sts_link has been low on any clock edge since its word was last read, and reads the live level otherwise.
- R11: A read releases only the latches of the word it reads. An event sampled on the same edge as that read is kept and is reported by the next read of the word.
- R12: Address 0 bit 15 (ctl_soft_reset) and bit 9 (ctl_restart_an) are set by writing 1. Each then stays 1 for exactly SC_CYCLES cycles and clears by itself. Writing 0 to them does nothing.
- R13: sts_an_done is shown live at address 1 bit 5 and at address 17 bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_speed | input | 1 | Reset value of the speed bit |
| strap_an_en | input | 1 | Reset value of the auto-negotiation enable bit |
| strap_duplex | input | 1 | Reset value of the duplex bit |
| strap_isolate | input | 1 | Reset value of the isolate bit |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_hit | output | 1 | Addressed register exists |
| rsp_rdata | output | 16 | Read data |
| sts_link | input | 1 | Live link state |
| sts_an_done | input | 1 | Auto-negotiation finished |
| sts_remote_fault | input | 1 | Remote fault event |
| sts_jabber | input | 1 | Jabber event |
| sts_rx_err | input | 1 | Receive error event |
| ctl_soft_reset | output | 1 | Self-clearing reset command |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_speed | output | 1 | Speed select |
| ctl_an_en | output | 1 | Auto-negotiation enable |
| ctl_power_down | output | 1 | Power-down request |
| ctl_isolate | output | 1 | Isolate request |
| ctl_restart_an | output | 1 | Self-clearing auto-negotiation restart |
| ctl_duplex | output | 1 | Duplex select |
| ctl_test_mode | output | 3 | Test mode bits |
| ctl_scramble_bypass | output | 1 | Scrambler bypass |

## Verification
A status event and the read that releases its latch can fall on the same clock edge. The bench provokes this by raising sts_jabber for one cycle in exactly the cycle a read of address 1 is presented. That read must still report the earlier cleared value, the next read must report the event, and a third read must show the live low level. The bench applies the same reasoning to the shared link input, where reading one word must leave the other word's latch untouched. It also interleaves random writes and reads against a shadow model once the unlock bit is set.

// File: rtl/phy_regbank_pkg.sv
package phy_regbank_pkg;
   localparam int unsigned ADDR_W = 5;
   localparam int unsigned DATA_W = 16;

   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [DATA_W-1:0] word_t;

   localparam addr_t RA_CTRL = 5'd0;
   localparam addr_t RA_STAT = 5'd1;
   localparam addr_t RA_IDHI = 5'd2;
   localparam addr_t RA_IDLO = 5'd3;
   localparam addr_t RA_XCTL = 5'd16;
   localparam addr_t RA_QSTS = 5'd17;

   // control word bit positions
   localparam int unsigned C_SRST   = 15;
   localparam int unsigned C_LOOP   = 14;
   localparam int unsigned C_SPEED  = 13;
   localparam int unsigned C_ANEN   = 12;
   localparam int unsigned C_PDOWN  = 11;
   localparam int unsigned C_ISO    = 10;
   localparam int unsigned C_RESTRT = 9;
   localparam int unsigned C_DUPLX  = 8;

   // extended control word bit positions
   localparam int unsigned X_UNLOCK = 15;
   localparam int unsigned X_TST_HI = 14;
   localparam int unsigned X_TST_LO = 12;
   localparam int unsigned X_SCRB   = 0;

   // self-clearing channel indices
   localparam int unsigned SC_N      = 2;
   localparam int unsigned SC_SRST   = 0;
   localparam int unsigned SC_RESTRT = 1;

   // latch-high channel indices
   localparam int unsigned LH_N      = 4;
   localparam int unsigned LH_S_RF   = 0;
   localparam int unsigned LH_S_JAB  = 1;
   localparam int unsigned LH_Q_RF   = 2;
   localparam int unsigned LH_Q_RXE  = 3;

   // latch-low channel indices
   localparam int unsigned LL_N      = 2;
   localparam int unsigned LL_S_LINK = 0;
   localparam int unsigned LL_Q_LINK = 1;

   function automatic logic addr_present(input addr_t a);
      return (a == RA_CTRL) || (a == RA_STAT) || (a == RA_IDHI) ||
             (a == RA_IDLO) || (a == RA_XCTL) || (a == RA_QSTS);
   endfunction
endpackage

// File: rtl/phy_regbank_evlatch.sv
module phy_regbank_evlatch #(
   parameter int unsigned N        = 1,
   parameter bit          ACT_HIGH = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cond,
   input  logic [N-1:0] release_i,
   output logic [N-1:0] shown
);
   generate
      if (N < 1) begin : g_bad_n
         $error("phy_regbank_evlatch: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] event_seen;
   logic [N-1:0] ev;

   generate
      if (ACT_HIGH) begin : g_high
         assign ev    = cond;
         assign shown = event_seen;
      end else begin : g_low
         assign ev    = ~cond;
         assign shown = ~event_seen;
      end
   endgenerate

   // an event on the release edge survives, giving it to the next read
   always_ff @(posedge clk) begin
      if (!rst_n) event_seen <= '0;
      else        event_seen <= ev | (event_seen & ~release_i);
   end
endmodule

// File: rtl/phy_regbank_selfclr.sv
module phy_regbank_selfclr #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   output logic active
);
   localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("phy_regbank_selfclr: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         remain <= '0;
      end else if (set) begin
         active <= 1'b1;
         remain <= CNT_W'(CYCLES - 1);
      end else if (active) begin
         if (remain == '0) active <= 1'b0;
         else              remain <= remain - 1'b1;
      end
   end
endmodule

// File: rtl/phy_regbank_rdmux.sv
module phy_regbank_rdmux
   import phy_regbank_pkg::*;
(
   input  addr_t addr,
   input  word_t img_ctrl,
   input  word_t img_stat,
   input  word_t img_idhi,
   input  word_t img_idlo,
   input  word_t img_xctl,
   input  word_t img_qsts,
   output word_t rdata,
   output logic  hit
);
   always_comb begin
      rdata = '0;
      hit   = addr_present(addr);
      unique case (addr)
         RA_CTRL: rdata = img_ctrl;
         RA_STAT: rdata = img_stat;
         RA_IDHI: rdata = img_idhi;
         RA_IDLO: rdata = img_idlo;
         RA_XCTL: rdata = img_xctl;
         RA_QSTS: rdata = img_qsts;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/phy_regbank.sv
module phy_regbank
   import phy_regbank_pkg::*;
#(
   parameter int unsigned SC_CYCLES = 16,
   parameter logic [15:0] ID_HI     = 16'h0015,
   parameter logic [15:0] ID_LO     = 16'hF441,
   parameter logic [4:0]  ABILITY   = 5'b01111
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        strap_speed,
   input  logic        strap_an_en,
   input  logic        strap_duplex,
   input  logic        strap_isolate,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [4:0]  req_addr,
   input  logic [15:0] req_wdata,
   output logic        rsp_valid,
   output logic        rsp_hit,
   output logic [15:0] rsp_rdata,
   input  logic        sts_link,
   input  logic        sts_an_done,
   input  logic        sts_remote_fault,
   input  logic        sts_jabber,
   input  logic        sts_rx_err,
   output logic        ctl_soft_reset,
   output logic        ctl_loopback,
   output logic        ctl_speed,
   output logic        ctl_an_en,
   output logic        ctl_power_down,
   output logic        ctl_isolate,
   output logic        ctl_restart_an,
   output logic        ctl_duplex,
   output logic [2:0]  ctl_test_mode,
   output logic        ctl_scramble_bypass
);
   localparam int unsigned TST_W = X_TST_HI - X_TST_LO + 1;

   generate
      if (SC_CYCLES < 1) begin : g_bad_sc
         $error("phy_regbank: SC_CYCLES must be at least 1");
      end
      if (TST_W != 3) begin : g_bad_tst
         $error("phy_regbank: test field width mismatch");
      end
   endgenerate

   // request decode
   logic wr_now, rd_now;
   logic wr_ctrl, wr_xctl, rd_stat, rd_qsts;
   assign wr_now  = req_valid &  req_write;
   assign rd_now  = req_valid & ~req_write;
   assign wr_ctrl = wr_now && (req_addr == RA_CTRL);
   assign wr_xctl = wr_now && (req_addr == RA_XCTL);
   assign rd_stat = rd_now && (req_addr == RA_STAT);
   assign rd_qsts = rd_now && (req_addr == RA_QSTS);

   // stored control state
   logic             override_q;
   logic             loop_q, speed_q, anen_q, pdown_q, iso_q, duplx_q, scrb_q;
   logic [TST_W-1:0] test_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         override_q <= 1'b0;
         loop_q     <= 1'b0;
         pdown_q    <= 1'b0;
         iso_q      <= strap_isolate;
         speed_q    <= strap_speed;
         anen_q     <= strap_an_en;
         duplx_q    <= strap_duplex;
         test_q     <= '0;
         scrb_q     <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            loop_q  <= req_wdata[C_LOOP];
            pdown_q <= req_wdata[C_PDOWN];
            iso_q   <= req_wdata[C_ISO];
            if (override_q) begin
               speed_q <= req_wdata[C_SPEED];
               anen_q  <= req_wdata[C_ANEN];
               duplx_q <= req_wdata[C_DUPLX];
            end
         end
         if (wr_xctl) begin
            override_q <= req_wdata[X_UNLOCK];
            test_q     <= req_wdata[X_TST_HI:X_TST_LO];
            scrb_q     <= req_wdata[X_SCRB];
         end
      end
   end

   // self-clearing command bits
   logic [SC_N-1:0] sc_set, sc_act;
   assign sc_set[SC_SRST]   = wr_ctrl & req_wdata[C_SRST];
   assign sc_set[SC_RESTRT] = wr_ctrl & req_wdata[C_RESTRT];

   generate
      for (genvar g = 0; g < SC_N; g++) begin : g_sc
         phy_regbank_selfclr #(.CYCLES(SC_CYCLES)) u_sc (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (sc_set[g]),
            .active (sc_act[g])
         );
      end
   endgenerate

   // event latches
   logic [LH_N-1:0] lh_cond, lh_rel, lh_disp;
   logic [LL_N-1:0] ll_cond, ll_rel, ll_disp;

   assign lh_cond[LH_S_RF]  = sts_remote_fault;
   assign lh_cond[LH_S_JAB] = sts_jabber;
   assign lh_cond[LH_Q_RF]  = sts_remote_fault;
   assign lh_cond[LH_Q_RXE] = sts_rx_err;
   assign lh_rel[LH_S_RF]   = rd_stat;
   assign lh_rel[LH_S_JAB]  = rd_stat;
   assign lh_rel[LH_Q_RF]   = rd_qsts;
   assign lh_rel[LH_Q_RXE]  = rd_qsts;

   assign ll_cond[LL_S_LINK] = sts_link;
   assign ll_cond[LL_Q_LINK] = sts_link;
   assign ll_rel[LL_S_LINK]  = rd_stat;
   assign ll_rel[LL_Q_LINK]  = rd_qsts;

   phy_regbank_evlatch #(.N(LH_N), .ACT_HIGH(1'b1)) u_lh (
      .clk       (clk),
      .rst_n     (rst_n),
      .cond      (lh_cond),
      .release_i (lh_rel),
      .shown     (lh_disp)
   );

   phy_regbank_evlatch #(.N(LL_N), .ACT_HIGH(1'b0)) u_ll (
      .clk       (clk),
      .rst_n     (rst_n),
      .cond      (ll_cond),
      .release_i (ll_rel),
      .shown     (ll_disp)
   );

   // word images
   word_t img_ctrl, img_stat, img_xctl, img_qsts;

   always_comb begin
      img_ctrl           = '0;
      img_ctrl[C_SRST]   = sc_act[SC_SRST];
      img_ctrl[C_LOOP]   = loop_q;
      img_ctrl[C_SPEED]  = speed_q;
      img_ctrl[C_ANEN]   = anen_q;
      img_ctrl[C_PDOWN]  = pdown_q;
      img_ctrl[C_ISO]    = iso_q;
      img_ctrl[C_RESTRT] = sc_act[SC_RESTRT];
      img_ctrl[C_DUPLX]  = duplx_q;

      img_stat        = '0;
      img_stat[15:11] = ABILITY;
      img_stat[5]     = sts_an_done;
      img_stat[4]     = lh_disp[LH_S_RF];
      img_stat[3]     = 1'b1;
      img_stat[2]     = ll_disp[LL_S_LINK];
      img_stat[1]     = lh_disp[LH_S_JAB];
      img_stat[0]     = 1'b1;

      img_xctl                    = '0;
      img_xctl[X_UNLOCK]          = override_q;
      img_xctl[X_TST_HI:X_TST_LO] = test_q;
      img_xctl[X_SCRB]            = scrb_q;

      img_qsts     = '0;
      img_qsts[15] = ll_disp[LL_Q_LINK];
      img_qsts[14] = sts_an_done;
      img_qsts[1]  = lh_disp[LH_Q_RF];
      img_qsts[0]  = lh_disp[LH_Q_RXE];
   end

   word_t mux_data;
   logic  mux_hit;

   phy_regbank_rdmux u_mux (
      .addr     (req_addr),
      .img_ctrl (img_ctrl),
      .img_stat (img_stat),
      .img_idhi (ID_HI),
      .img_idlo (ID_LO),
      .img_xctl (img_xctl),
      .img_qsts (img_qsts),
      .rdata    (mux_data),
      .hit      (mux_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_now;
         rsp_hit   <= rd_now & mux_hit;
         rsp_rdata <= rd_now ? mux_data : '0;
      end
   end

   assign ctl_soft_reset      = sc_act[SC_SRST];
   assign ctl_restart_an      = sc_act[SC_RESTRT];
   assign ctl_loopback        = loop_q;
   assign ctl_speed           = speed_q;
   assign ctl_an_en           = anen_q;
   assign ctl_power_down      = pdown_q;
   assign ctl_isolate         = iso_q;
   assign ctl_duplex          = duplx_q;
   assign ctl_test_mode       = test_q;
   assign ctl_scramble_bypass = scrb_q;
endmodule

// File: rtl/phy_regbank_chk.sv
module phy_regbank_chk #(
   parameter int unsigned SC_CYCLES = 16,
   parameter logic [15:0] ID_HI     = 16'h0015
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [4:0]  req_addr,
   input logic        rsp_valid,
   input logic        rsp_hit,
   input logic [15:0] rsp_rdata,
   input logic        sts_jabber,
   input logic        ctl_soft_reset,
   input logic        ctl_speed,
   input logic        ctl_an_en,
   input logic        ctl_duplex,
   input logic        override_q,
   input logic [3:0]  lh_disp
);
   int unsigned sc_run;

   always_ff @(posedge clk) begin
      if (!rst_n)              sc_run <= 0;
      else if (ctl_soft_reset) sc_run <= sc_run + 1;
      else                     sc_run <= 0;
   end

   AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid); // R2

   AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rsp_valid); // R2

   AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == 5'd7) |=> (!rsp_hit && rsp_rdata == 16'h0)); // R1

   AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == 5'd2) |=> (rsp_hit && rsp_rdata == ID_HI)); // R3

   AST_LOCKED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == 5'd0 && !override_q)
      |=> ($stable(ctl_speed) && $stable(ctl_an_en) && $stable(ctl_duplex))); // R5

   AST_JAB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      sts_jabber |=> lh_disp[1]); // R9

   AST_JAB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lh_disp[1] && !(req_valid && !req_write && req_addr == 5'd1)) |=> lh_disp[1]); // R11

   AST_SC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      sc_run <= SC_CYCLES); // R12
endmodule

bind phy_regbank phy_regbank_chk #(.SC_CYCLES(SC_CYCLES), .ID_HI(ID_HI)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_write      (req_write),
   .req_addr       (req_addr),
   .rsp_valid      (rsp_valid),
   .rsp_hit        (rsp_hit),
   .rsp_rdata      (rsp_rdata),
   .sts_jabber     (sts_jabber),
   .ctl_soft_reset (ctl_soft_reset),
   .ctl_speed      (ctl_speed),
   .ctl_an_en      (ctl_an_en),
   .ctl_duplex     (ctl_duplex),
   .override_q     (override_q),
   .lh_disp        (lh_disp)
);

// File: tb/phy_regbank_tb.sv
module phy_regbank_tb;
   localparam int unsigned SC      = 16;
   localparam logic [15:0] IDH     = 16'h0015;
   localparam logic [15:0] IDL     = 16'hF441;
   localparam logic [4:0]  ABL     = 5'b01111;
   localparam logic [15:0] STAT_FX = 16'h7809;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap_speed = 1'b1, strap_an_en = 1'b1, strap_duplex = 1'b0, strap_isolate = 1'b1;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [4:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic rsp_valid, rsp_hit;
   logic [15:0] rsp_rdata;
   logic sts_link = 1'b1, sts_an_done = 1'b0, sts_remote_fault = 1'b0;
   logic sts_jabber = 1'b0, sts_rx_err = 1'b0;
   logic ctl_soft_reset, ctl_loopback, ctl_speed, ctl_an_en, ctl_power_down;
   logic ctl_isolate, ctl_restart_an, ctl_duplex, ctl_scramble_bypass;
   logic [2:0] ctl_test_mode;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   phy_regbank #(.SC_CYCLES(SC), .ID_HI(IDH), .ID_LO(IDL), .ABILITY(ABL)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .strap_speed(strap_speed), .strap_an_en(strap_an_en),
      .strap_duplex(strap_duplex), .strap_isolate(strap_isolate),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_rdata(rsp_rdata), .sts_link(sts_link), .sts_an_done(sts_an_done),
      .sts_remote_fault(sts_remote_fault), .sts_jabber(sts_jabber),
      .sts_rx_err(sts_rx_err), .ctl_soft_reset(ctl_soft_reset),
      .ctl_loopback(ctl_loopback), .ctl_speed(ctl_speed), .ctl_an_en(ctl_an_en),
      .ctl_power_down(ctl_power_down), .ctl_isolate(ctl_isolate),
      .ctl_restart_an(ctl_restart_an), .ctl_duplex(ctl_duplex),
      .ctl_test_mode(ctl_test_mode), .ctl_scramble_bypass(ctl_scramble_bypass)
   );

   function automatic bit present(input logic [4:0] a);
      return a == 0 || a == 1 || a == 2 || a == 3 || a == 16 || a == 17;
   endfunction

   function automatic logic [15:0] stat_word(input bit link, input bit an, input bit rf, input bit jab);
      logic [15:0] w;
      w = STAT_FX;
      w[2] = link; w[5] = an; w[4] = rf; w[1] = jab;
      return w;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d, output logic h);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      d = rsp_rdata; h = rsp_hit;
      total++;
      if (rsp_valid !== 1'b1) begin
         bad++;
         $display("FAIL R2 actual=%b expected=1", rsp_valid);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [15:0] d;
      logic h;
      logic [15:0] sh_ctrl, sh_xctl;
      int n;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state with straps
      rd(5'd0, d, h);  check("R8 ctrl", d, 16'h3400);
      check("R8 outs", {13'h0, ctl_speed, ctl_an_en, ctl_duplex}, 16'h0006);
      rd(5'd16, d, h); check("R8 xctl", d, 16'h0000);
      // R4 / R10 status after reset
      rd(5'd1, d, h);  check("R4 stat", d, stat_word(1, 0, 0, 0));
      // R3 identifiers
      rd(5'd2, d, h);  check("R3 idhi", {h, d[14:0]}, {1'b1, IDH[14:0]}); check("R3 idhi15", {15'h0, d[15]}, {15'h0, IDH[15]});
      rd(5'd3, d, h);  check("R3 idlo", d, IDL);
      wr(5'd3, 16'h1234);
      rd(5'd3, d, h);  check("R3 idlo write ignored", d, IDL);
      // R1 absent address
      wr(5'd5, 16'hFFFF);
      rd(5'd5, d, h);  check("R1 absent", {h, d[14:0]}, 16'h0);
      // R2 no response to write
      @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_addr = 5'd16; req_wdata = 16'h0;
      @(negedge clk); req_valid = 1'b0; req_write = 1'b0;
      check("R2 write no rsp", {15'h0, rsp_valid}, 16'h0);
      // R4 read-only words ignore writes
      wr(5'd1, 16'h0000);
      rd(5'd1, d, h);  check("R4 stat write ignored", d, stat_word(1, 0, 0, 0));
      wr(5'd17, 16'hFFFF);
      rd(5'd17, d, h); check("R4 qsts write ignored", d, 16'h8000);
      // R5 locked command bits, R6 isolate writable
      wr(5'd0, 16'h0100);
      rd(5'd0, d, h);  check("R5 locked", d, 16'h3000);
      wr(5'd16, 16'h8000);
      wr(5'd0, 16'h4100);
      rd(5'd0, d, h);  check("R5 unlocked", d, 16'h4100);
      check("R6 loopback out", {15'h0, ctl_loopback}, 16'h0001);
      // R7 zero-write-only bits
      wr(5'd16, 16'h8001);
      wr(5'd0, 16'h4100);
      rd(5'd16, d, h); check("R7 xctl zeros", d, 16'h8001);
      check("R7 test out", {13'h0, ctl_test_mode}, 16'h0);
      check("R7 pdown out", {15'h0, ctl_power_down}, 16'h0);
      // R13 live bits
      sts_an_done = 1'b1;
      rd(5'd1, d, h);  check("R13 stat an", {15'h0, d[5]}, 16'h1);
      rd(5'd17, d, h); check("R13 qsts an", {15'h0, d[14]}, 16'h1);
      sts_an_done = 1'b0;
      // R9 latch high jabber pulse
      @(negedge clk); sts_jabber = 1'b1;
      @(negedge clk); sts_jabber = 1'b0;
      rd(5'd1, d, h);  check("R9 jab latched", {15'h0, d[1]}, 16'h1);
      rd(5'd1, d, h);  check("R9 jab released", {15'h0, d[1]}, 16'h0);
      // R9 persisting condition
      sts_jabber = 1'b1;
      rd(5'd1, d, h);  rd(5'd1, d, h);
      check("R9 jab persists", {15'h0, d[1]}, 16'h1);
      sts_jabber = 1'b0;
      rd(5'd1, d, h); rd(5'd1, d, h);
      // R11 event on the release edge
      @(negedge clk); sts_jabber = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 5'd1;
      @(negedge clk); sts_jabber = 1'b0; req_valid = 1'b0;
      check("R11 same edge old", {15'h0, rsp_rdata[1]}, 16'h0);
      rd(5'd1, d, h);  check("R11 same edge kept", {15'h0, d[1]}, 16'h1);
      rd(5'd1, d, h);  check("R11 then live", {15'h0, d[1]}, 16'h0);
      // R10 latch low link, R11 independence
      @(negedge clk); sts_link = 1'b0;
      @(negedge clk); sts_link = 1'b1;
      rd(5'd1, d, h);  check("R10 link latched low", {15'h0, d[2]}, 16'h0);
      rd(5'd1, d, h);  check("R10 link live", {15'h0, d[2]}, 16'h1);
      rd(5'd17, d, h); check("R11 qsts link independent", {15'h0, d[15]}, 16'h0);
      rd(5'd17, d, h); check("R10 qsts link live", {15'h0, d[15]}, 16'h1);
      // R9 remote fault and rx error
      @(negedge clk); sts_remote_fault = 1'b1; sts_rx_err = 1'b1;
      @(negedge clk); sts_remote_fault = 1'b0; sts_rx_err = 1'b0;
      rd(5'd17, d, h); check("R9 qsts rf rxe", d, 16'h8003);
      rd(5'd1, d, h);  check("R9 stat rf", d, stat_word(1, 0, 1, 0));
      rd(5'd17, d, h); check("R9 qsts cleared", d, 16'h8000);
      // R12 self-clearing soft reset
      wr(5'd0, 16'hC100);
      n = 0;
      while (ctl_soft_reset === 1'b1 && n < 100) begin n++; @(negedge clk); end
      check("R12 srst width", 16'(n), 16'(SC));
      rd(5'd0, d, h);  check("R12 srst cleared", d, 16'h4100);
      wr(5'd0, 16'h4300);
      n = 0;
      while (ctl_restart_an === 1'b1 && n < 100) begin n++; @(negedge clk); end
      check("R12 restart width", 16'(n), 16'(SC));
      // random mix
      sh_ctrl = 16'h4100; sh_xctl = 16'h8001;
      for (int i = 0; i < 300; i++) begin
         int op;
         logic [4:0] a;
         logic [15:0] w;
         op = $urandom_range(0, 2);
         if (op == 0) begin
            w = 16'($urandom) & 16'h7500;
            wr(5'd0, w); sh_ctrl = w;
         end else if (op == 1) begin
            w = 16'h8000 | (16'($urandom) & 16'h0001);
            wr(5'd16, w); sh_xctl = w;
         end else begin
            a = 5'($urandom);
            if ($urandom_range(0, 1) == 1) a = 5'(($urandom_range(0, 5) < 4) ? $urandom_range(0, 3) : $urandom_range(16, 17));
            rd(a, d, h);
            check("R1 rand hit", {15'h0, h}, {15'h0, present(a)});
            case (a)
               5'd0:  check("R6 rand ctrl", d, sh_ctrl);
               5'd1:  check("R4 rand stat", d, stat_word(1, 0, 0, 0));
               5'd2:  check("R3 rand idhi", d, IDH);
               5'd3:  check("R3 rand idlo", d, IDL);
               5'd16: check("R6 rand xctl", d, sh_xctl);
               5'd17: check("R4 rand qsts", d, 16'h8000);
               default: check("R1 rand absent", d, 16'h0);
            endcase
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule